// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a read or write burst in a synchronous DRAM. A command supplies a start column. The burst length and ordering come from the mode register word, which the block samples on that command. From the next cycle the block steps through the columns of the burst. It reports each address with a valid strobe and marks the final beat of a finite burst with a done pulse.

Finite bursts stay inside the naturally aligned block whose size is the burst length. Sequential order counts upward and wraps inside that block. Interleaved order flips the low address bits with the beat index. The page mode never ends by itself: it walks all 256 columns of a row, comes back to the start column, and only a burst stop ends it. A new command arriving mid-burst takes over immediately. A write can be cut to a single beat by the single-write mode bit.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and after reset release with no command, `valid_o` and `done_o` are 0 and `col_o` is 0.
- R2: On the cycle after `start_i` is sampled high, `valid_o` is 1 and `col_o` equals `start_col_i[7:0]`. Bits 9:8 of `start_col_i` have no effect.
- R3: With mode bit 3 = 0, lengths 2, 4 and 8 produce beat b at `(s & ~(L-1)) | ((s + b) & (L-1))`, where s is the start column and L is the length.
- R4: With mode bit 3 = 1 and a finite length L > 1, beat b is at `s ^ b`.
- R5: Mode bits [2:0] select the length: 0→1, 1→2, 2→4, 3→8, 7→page. The reserved codes 4, 5 and 6 give length 1.
- R6: `done_o` is 1 together with `valid_o` on the last beat of a finite burst. In the following cycle `valid_o` is 0 unless a new command was given.
- R7: In page mode, beat b is at `(s + b) mod 256`. The burst returns to s at beat 256, and `done_o` never rises. Page bursts always use sequential order.
- R8: A cycle with `stop_i` high and `start_i` low ends the burst: `valid_o` is 0 from the next cycle and no `done_o` is given.
- R9: When mode bit 7 = 1, a write burst (`is_write_i` = 1) has length 1 for any length code. Reads keep the programmed length.
- R10: A `start_i` during a burst restarts the sequence from the new start column on the next cycle, using the mode word sampled with it.
- R11: Changes of `mode_i` while a burst runs do not alter that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 8 | Mode word: [2:0] length code, [3] interleaved, [7] single-write |
| start_i | input | 1 | Read or write command issued |
| is_write_i | input | 1 | Command is a write |
| start_col_i | input | 10 | Start column; bits 9:8 ignored |
| stop_i | input | 1 | Burst stop |
| col_o | output | 8 | Column of the current beat |
| valid_o | output | 1 | Beat present |
| done_o | output | 1 | Last beat of a finite burst |

## Verification
The bench sweeps every one of the 256 start columns against every non-page length code in both orderings. This separates wrap-inside-block behaviour from plain incrementing, and the XOR order from sequential order. It also confirms that reserved codes collapse to one beat. Random upper column bits show that bits 9:8 are ignored. Directed runs cover the following:
- A page burst starting near the top of the row, which exposes the wrap at 256.
- Single-write against read and against burst-write, which separates direction handling.
- Mid-burst restarts, stops, and mode changes, which separate command takeover from mode sampling.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int MODE_W    = 8;
  localparam int TYPE_BIT  = 3;
  localparam int WMODE_BIT = 7;

  typedef struct packed {
    logic       full;  // page burst, ends only on stop
    logic       ilv;   // interleaved order
    logic [1:0] lg2;   // log2 of finite length
  } burst_cfg_t;
endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
  import burst_col_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              is_write_i,
  output burst_cfg_t        cfg_o
);
  always_comb begin
    cfg_o = '0;
    unique case (mode_i[2:0])
      3'd0: cfg_o.lg2 = 2'd0;
      3'd1: cfg_o.lg2 = 2'd1;
      3'd2: cfg_o.lg2 = 2'd2;
      3'd3: cfg_o.lg2 = 2'd3;
      3'd7: cfg_o.full = 1'b1;
      default: cfg_o.lg2 = 2'd0;  // reserved
    endcase
    cfg_o.ilv = mode_i[TYPE_BIT] & ~cfg_o.full;
    if (is_write_i && mode_i[WMODE_BIT]) cfg_o = '0;
  end
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  burst_cfg_t       cfg_i,
  input  logic [COL_W-1:0] col_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] mask_o,
  output burst_cfg_t       cfg_o,
  output logic             last_o
);
  logic             active_q;
  logic [COL_W-1:0] beat_q, base_q;
  burst_cfg_t       cfg_q;

  always_comb begin
    if (cfg_q.full) mask_o = '1;
    else            mask_o = COL_W'((32'd1 << cfg_q.lg2) - 32'd1);
  end

  assign last_o   = active_q & ~cfg_q.full & (beat_q == mask_o);
  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign base_o   = base_q;
  assign cfg_o    = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      cfg_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      base_q   <= col_i;
      cfg_q    <= cfg_i;
    end else if (stop_i || last_o) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (active_q) begin
      beat_q   <= beat_q + 1'b1;  // page wraps modulo 2**COL_W
    end
  end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + beat_i;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    always_comb begin
      if (!mask_i[i])  col_o[i] = base_i[i];
      else if (ilv_i)  col_o[i] = base_i[i] ^ beat_i[i];
      else             col_o[i] = sum[i];
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              start_i,
  input  logic              is_write_i,
  input  logic [ADDR_W-1:0] start_col_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              done_o
);
  burst_cfg_t       cfg_new, cfg_q;
  logic             active;
  logic             full_q;
  logic [COL_W-1:0] beat, base, mask, col_raw;
  logic             unused_bits;

  assign unused_bits = ^{start_col_i[ADDR_W-1:COL_W], mode_i[6:4]};

  burst_mode_decode u_dec (
    .mode_i     (mode_i),
    .is_write_i (is_write_i),
    .cfg_o      (cfg_new)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .cfg_i    (cfg_new),
    .col_i    (start_col_i[COL_W-1:0]),
    .active_o (active),
    .beat_o   (beat),
    .base_o   (base),
    .mask_o   (mask),
    .cfg_o    (cfg_q),
    .last_o   (done_o)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base_i (base),
    .beat_i (beat),
    .mask_i (mask),
    .ilv_i  (cfg_q.ilv),
    .col_o  (col_raw)
  );

  assign full_q  = cfg_q.full;
  assign valid_o = active;
  assign col_o   = active ? col_raw : '0;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W  = 8,
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stop_i,
  input logic [ADDR_W-1:0] start_col_i,
  input logic [COL_W-1:0]  col_o,
  input logic              valid_o,
  input logic              done_o,
  input logic              full_q
);
  p_start_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && col_o == $past(start_col_i[COL_W-1:0]));

  p_done_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);

  p_done_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !valid_o);

  p_stop_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !valid_o && !done_o);

  p_page_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && full_q && !start_i && !stop_i |=>
      valid_o && !done_o && col_o == COL_W'($past(col_o) + 1'b1));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stop_i      (stop_i),
  .start_col_i (start_col_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .done_o      (done_o),
  .full_q      (full_q)
);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] mode_i = '0;
  logic       start_i = 1'b0;
  logic       is_write_i = 1'b0;
  logic [9:0] start_col_i = '0;
  logic       stop_i = 1'b0;
  logic [7:0] col_o;
  logic       valid_o, done_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  burst_col_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .start_i(start_i),
    .is_write_i(is_write_i), .start_col_i(start_col_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_len(input int code, input bit wm, input bit wr);
    if (wr && wm) return 1;
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 256;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int b, input int len, input bit ilv);
    int m;
    if (len == 256) return (s + b) % 256;
    m = len - 1;
    if (ilv) return s ^ b;
    return (s & ~m & 255) | ((s + b) & m);
  endfunction

  // Issues a finite burst and checks every beat plus the idle cycle after it.
  task automatic run_burst(input int code, input bit typ, input bit wm, input bit wr,
                           input logic [9:0] col, input string req);
    int len, s;
    @(negedge clk_i);
    mode_i = {wm, 3'b000, typ, 3'(code)};
    is_write_i = wr; start_col_i = col; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    len = exp_len(code, wm, wr);
    s = int'(col[7:0]);
    for (int b = 0; b < len; b++) begin
      check(valid_o === 1'b1, req, valid_o, 1);
      check(col_o == 8'(exp_col(s, b, len, typ && len > 1)), req, col_o,
            exp_col(s, b, len, typ && len > 1));
      check(done_o === (b == len - 1), "R6", done_o, b == len - 1);
      @(negedge clk_i);
    end
    check(valid_o === 1'b0, "R6", valid_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int s;
    // R1 reset state
    repeat (3) @(negedge clk_i);
    check(valid_o === 1'b0 && done_o === 1'b0, "R1", valid_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(valid_o === 1'b0 && done_o === 1'b0 && col_o == 8'd0, "R1", col_o, 0);

    // R2 R3 R4 R5 sweep: every start column, every finite code, both orders
    for (int code = 0; code < 7; code++)
      for (int typ = 0; typ < 2; typ++)
        for (int c = 0; c < 256; c++)
          run_burst(code, typ[0], 1'b0, 1'b0, {2'(c * 7 + code), 8'(c)},
                    code > 3 ? "R5" : (code == 0 ? "R2" : (typ != 0 ? "R4" : "R3")));

    // R9 single write vs read vs burst write
    run_burst(3, 1'b0, 1'b1, 1'b1, 10'd13, "R9");
    run_burst(3, 1'b0, 1'b1, 1'b0, 10'd13, "R9");
    run_burst(3, 1'b0, 1'b0, 1'b1, 10'd13, "R9");
    run_burst(7, 1'b1, 1'b1, 1'b1, 10'd200, "R9");

    // R7 page burst across the row end, then R8 stop
    @(negedge clk_i);
    mode_i = 8'h0F; is_write_i = 1'b0; start_col_i = 10'd250; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int b = 0; b < 262; b++) begin
      check(valid_o === 1'b1 && done_o === 1'b0, "R7", done_o, 0);
      check(col_o == 8'((250 + b) % 256), "R7", col_o, (250 + b) % 256);
      if (b == 261) stop_i = 1'b1;
      @(negedge clk_i);
    end
    stop_i = 1'b0;
    check(valid_o === 1'b0 && done_o === 1'b0, "R8", valid_o, 0);
    repeat (3) @(negedge clk_i);
    check(valid_o === 1'b0, "R8", valid_o, 0);

    // R8 stop mid finite burst: no done pulse
    mode_i = 8'h03; start_col_i = 10'd40; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    stop_i = 1'b1;
    check(col_o == 8'd41, "R8", col_o, 41);
    @(negedge clk_i);
    stop_i = 1'b0;
    check(valid_o === 1'b0 && done_o === 1'b0, "R8", valid_o, 0);

    // R10 restart mid burst with a new column and mode
    mode_i = 8'h03; start_col_i = 10'd5; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(col_o == 8'd0, "R3", col_o, 0);  // 5,6,7,0
    mode_i = 8'h02; start_col_i = 10'd22; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    s = 22;
    for (int b = 0; b < 4; b++) begin
      check(col_o == 8'(exp_col(s, b, 4, 1'b0)), "R10", col_o, exp_col(s, b, 4, 1'b0));
      check(done_o === (b == 3), "R10", done_o, b == 3);
      @(negedge clk_i);
    end
    check(valid_o === 1'b0, "R10", valid_o, 0);

    // R11 mode change during a burst has no effect
    mode_i = 8'h03; start_col_i = 10'd3; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    mode_i = 8'h09;
    for (int b = 0; b < 8; b++) begin
      check(col_o == 8'(exp_col(3, b, 8, 1'b0)), "R11", col_o, exp_col(3, b, 8, 1'b0));
      check(done_o === (b == 7), "R11", done_o, b == 7);
      @(negedge clk_i);
    end
    check(valid_o === 1'b0, "R11", valid_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule